// File: doc/BRIEF.md
# Center-Aligned PWM Channel

This block produces one symmetric PWM waveform from an up/down counter. The counter rises from zero to a programmable modulus and then falls back to zero, so one period lasts twice the modulus in enabled clocks. A compare value sets where the pin changes. The pin changes once on the rising slope and once on the falling slope, which centres the pulse on the counter valley.

A two-bit edge select sets the pin action. One setting gives a pulse that is high around the valley. Another gives a pulse that is low around the valley. A third leaves the pin alone while the compare logic keeps running. Two sticky flags record compare hits and counter turnarounds at the top. The compare flag, gated by an enable, drives an interrupt request. Modulus and compare values are sampled into working copies only when the counter turns at the top, so software can write them at any time.

Top module: `cpwm_channel`

## Requirements
- R1: The counter visits 0,1,…,M,M-1,…,1 and repeats, where M is the working modulus, so the top is reached once every 2·M enabled clocks. After reset the first enabled edge only captures the inputs. The counter first sits at M on the tenth enabled edge (edge index 9 when M=8).
- R2: With edge select 2'b10 and 0<C<M, the pin is high for exactly 2·C clocks of each 2·M clock period.
- R3: matchFlag rises on the edge where the counter equals the working compare value C, in either direction (first hit at enabled edge index C+1 after reset). irq equals matchFlag AND intEn.
- R4: With edge select 2'b00 the pin keeps its current level, while matchFlag still sets on compare hits.
- R5: With edge select 2'b10, a hit on the falling side drives the pin high and a hit on the rising side drives it low. The hit at the top counts as falling; the hit at zero counts as rising.
- R6: With edge select bit 0 set (2'b01 or 2'b11), the actions are reversed: falling-side hit drives low, rising-side hit drives high. The pin is high for 2·M−2·C clocks per period.
- R7: ovfFlag rises on the edge where the counter sits at M while rising.
- R8: Both flags are sticky. Each is cleared by a 1 on its clear input. An event in the same cycle as a clear leaves the flag set.
- R9: modIn and cmpIn are copied into the working values on the first enabled edge after reset and on each top turnaround. A change at any other time takes effect only from the next turnaround.
- R10: Reset gives pin low, both flags clear, irq low. While enable is low the counter, pin and flags (apart from clears) hold.
- R11: C=0 keeps the pin at its inactive level. C≥M keeps it at its active level (high for 2'b10, low for bit 0 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| enable | input | 1 | Counter advance enable |
| modIn | input | CNT_W | Requested modulus |
| cmpIn | input | CNT_W | Requested compare value |
| edgeSel | input | 2 | Pin action select |
| intEn | input | 1 | Interrupt enable for the compare flag |
| clrMatch | input | 1 | Write-one clear of matchFlag |
| clrOvf | input | 1 | Write-one clear of ovfFlag |
| pwmOut | output | 1 | PWM pin |
| irq | output | 1 | Channel interrupt request |
| matchFlag | output | 1 | Sticky compare-hit flag |
| ovfFlag | output | 1 | Sticky top-turnaround flag |

## Verification
A counter that is off by one, or that turns in the wrong place, moves the first overflow away from edge index 9 and changes the measured duty within one period. A wrong direction bit sends a compare hit to the wrong side. That swaps the pin polarity or makes the measured high time differ from 2·C within one 2·M window. Working copies that update too early show up as a pin edge at the wrong compare point in the first period. A flag whose hold or clear priority is wrong shows up as matchFlag or ovfFlag at the wrong level on the very next edge.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture requested modulus / compare
    logic inc;      // counter + 1
    logic dec;      // counter - 1
    logic goUp;     // direction becomes rising
    logic goDown;   // direction becomes falling
  } cpwm_strobe_t;
endpackage

// File: rtl/cpwm_datapath.sv
module cpwm_datapath
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] modIn,
  input  logic [CNT_W-1:0] cmpIn,
  input  cpwm_strobe_t     strb,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic [CNT_W-1:0] modAct,
  output logic [CNT_W-1:0] cmpAct,
  output logic             primed
);
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      up     <= 1'b1;
      modAct <= '0;
      cmpAct <= '0;
      primed <= 1'b0;
    end else begin
      if (strb.load) begin
        modAct <= modIn;
        cmpAct <= cmpIn;
        primed <= 1'b1;
      end
      if (strb.inc)      cnt <= cnt + STEP;
      else if (strb.dec) cnt <= cnt - STEP;
      if (strb.goUp)        up <= 1'b1;
      else if (strb.goDown) up <= 1'b0;
    end
  end

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

  // R1
  cnt_move_chk: assert property (@(posedge clk) disable iff (rst)
    (en && primed && modAct != '0) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/cpwm_control.sv
module cpwm_control
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             up,
  input  logic [CNT_W-1:0] modAct,
  input  logic [CNT_W-1:0] cmpAct,
  input  logic             primed,
  input  logic [1:0]       edgeSel,
  input  logic             clrMatch,
  input  logic             clrOvf,
  output cpwm_strobe_t     strb,
  output logic             pwm,
  output logic             matchFlag,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic run, atTop, atBottom;
  logic matchEv, ovfEv, fallSide, overCmp, pinCtl, activeLvl;

  assign run      = en & primed;
  assign atTop    = up & (cnt >= modAct);
  assign atBottom = ~up & (cnt == ZERO);

  // counter sequencing
  always_comb begin
    strb      = '0;
    strb.load = en & (~primed | (run & atTop));
    if (run) begin
      if (atTop) begin
        if (modAct != ZERO) begin
          strb.dec    = 1'b1;
          strb.goDown = 1'b1;
        end
      end else if (up) begin
        strb.inc = 1'b1;
      end else if (atBottom) begin
        strb.inc  = 1'b1;
        strb.goUp = 1'b1;
      end else begin
        strb.dec = 1'b1;
      end
    end
  end

  // event classification: top counts as falling side, zero as rising side
  assign matchEv   = run & (cnt == cmpAct);
  assign ovfEv     = run & atTop;
  assign fallSide  = atTop | (~up & (cnt != ZERO));
  assign overCmp   = cmpAct > modAct;
  assign pinCtl    = |edgeSel;
  assign activeLvl = ~edgeSel[0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      matchFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      pwm       <= 1'b0;
    end else begin
      matchFlag <= matchEv | (matchFlag & ~clrMatch);
      ovfFlag   <= ovfEv | (ovfFlag & ~clrOvf);
      if (run && pinCtl) begin
        if (overCmp)      pwm <= activeLvl;
        else if (matchEv) pwm <= fallSide ? activeLvl : ~activeLvl;
      end
    end
  end

  // R8
  match_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (matchFlag && !clrMatch) |=> matchFlag);

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && primed && up && cnt >= modAct) |=> ovfFlag);

  // R4
  pin_free_chk: assert property (@(posedge clk) disable iff (rst)
    (edgeSel == 2'b00) |=> $stable(pwm));
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] modIn,
  input  logic [CNT_W-1:0] cmpIn,
  input  logic [1:0]       edgeSel,
  input  logic             intEn,
  input  logic             clrMatch,
  input  logic             clrOvf,
  output logic             pwmOut,
  output logic             irq,
  output logic             matchFlag,
  output logic             ovfFlag
);
  cpwm_strobe_t     strb;
  logic [CNT_W-1:0] cnt, modAct, cmpAct;
  logic             up, primed;

  cpwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .en(enable), .modIn(modIn), .cmpIn(cmpIn),
    .strb(strb), .cnt(cnt), .up(up), .modAct(modAct), .cmpAct(cmpAct),
    .primed(primed)
  );

  cpwm_control #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .en(enable), .cnt(cnt), .up(up),
    .modAct(modAct), .cmpAct(cmpAct), .primed(primed), .edgeSel(edgeSel),
    .clrMatch(clrMatch), .clrOvf(clrOvf), .strb(strb), .pwm(pwmOut),
    .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  assign irq = matchFlag & intEn;

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!matchFlag) |-> !irq);
endmodule

// File: tb/cpwm_channel_test.sv
`timescale 1ns/1ps
module cpwm_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] modIn = '0;
  logic [15:0] cmpIn = '0;
  logic [1:0]  edgeSel = 2'b00;
  logic        intEn = 1'b0;
  logic        clrMatch = 1'b0;
  logic        clrOvf = 1'b0;
  logic        pwmOut, irq, matchFlag, ovfFlag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cpwm_channel #(.CNT_W(16)) uut (
    .clk(clk), .rst(rst), .enable(enable), .modIn(modIn), .cmpIn(cmpIn),
    .edgeSel(edgeSel), .intEn(intEn), .clrMatch(clrMatch), .clrOvf(clrOvf),
    .pwmOut(pwmOut), .irq(irq), .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  // {modulus, compare, edge select, expected high clocks per period}
  localparam int NV = 12;
  localparam logic [49:0] VECS [NV] = '{
    {16'd8,  16'd5,  2'b10, 16'd10},  // R2 R5
    {16'd8,  16'd5,  2'b01, 16'd6},   // R6
    {16'd8,  16'd5,  2'b11, 16'd6},   // R6
    {16'd8,  16'd0,  2'b10, 16'd0},   // R11
    {16'd8,  16'd8,  2'b10, 16'd16},  // R11
    {16'd8,  16'd12, 2'b10, 16'd16},  // R11
    {16'd8,  16'd0,  2'b01, 16'd16},  // R11
    {16'd8,  16'd12, 2'b01, 16'd0},   // R11
    {16'd5,  16'd2,  2'b10, 16'd4},   // R2
    {16'd3,  16'd1,  2'b01, 16'd4},   // R6
    {16'd8,  16'd5,  2'b00, 16'd0},   // R4
    {16'd1,  16'd1,  2'b10, 16'd2}    // R1 R11
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance n edges, then settle 1ns past the edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // reset, program, then enable: the next edge is enabled edge index 0
  task automatic start(input int m, input int c, input logic [1:0] s);
    rst = 1'b1; enable = 1'b0;
    modIn = 16'(m); cmpIn = 16'(c); edgeSel = s;
    clrMatch = 1'b0; clrOvf = 1'b0;
    tick(2);
    rst = 1'b0;
    tick(1);
    enable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R10 reset state
    tick(2);
    chk("R10 pin", int'(pwmOut), 0);
    chk("R10 matchFlag", int'(matchFlag), 0);
    chk("R10 ovfFlag", int'(ovfFlag), 0);
    chk("R10 irq", int'(irq), 0);

    // duty vectors
    for (int v = 0; v < NV; v++) begin
      int m, c, hi, exp;
      m   = int'(VECS[v][49:34]);
      c   = int'(VECS[v][33:18]);
      exp = int'(VECS[v][15:0]);
      start(m, c, VECS[v][17:16]);
      tick(2*m + 4);
      hi = 0;
      for (int k = 0; k < 2*m; k++) begin
        tick(1);
        if (pwmOut) hi++;
      end
      chk($sformatf("R2/R6/R11 vector %0d high clocks", v), hi, exp);
    end

    // timing of flags, clears, enable hold: M=8 C=5 high-true
    start(8, 5, 2'b10);
    intEn = 1'b1;
    tick(6);                                   // after edge 5
    chk("R3 no hit yet", int'(matchFlag), 0);
    tick(1);                                   // after edge 6
    chk("R3 rising hit", int'(matchFlag), 1);
    chk("R3 irq", int'(irq), 1);
    intEn = 1'b0; #1;
    chk("R3 irq gated", int'(irq), 0);
    tick(1);                                   // after edge 7
    clrMatch = 1'b1;
    tick(1);                                   // after edge 8
    clrMatch = 1'b0;
    chk("R8 clear", int'(matchFlag), 0);
    chk("R7 not yet", int'(ovfFlag), 0);
    tick(1);                                   // after edge 9
    chk("R7 R1 top", int'(ovfFlag), 1);
    tick(2);                                   // after edge 11
    chk("R8 stays clear", int'(matchFlag), 0);
    clrMatch = 1'b1;
    tick(1);                                   // after edge 12
    clrMatch = 1'b0;
    chk("R8 event beats clear", int'(matchFlag), 1);
    chk("R5 falling hit high", int'(pwmOut), 1);
    clrOvf = 1'b1;
    tick(1);                                   // after edge 13
    clrOvf = 1'b0;
    chk("R8 ovf clear", int'(ovfFlag), 0);
    enable = 1'b0;
    tick(20);
    chk("R10 hold pin", int'(pwmOut), 1);
    chk("R10 hold flag", int'(ovfFlag), 0);
    enable = 1'b1;
    tick(8);                                   // after edge 21
    chk("R10 resumed pin", int'(pwmOut), 1);
    tick(1);                                   // after edge 22
    chk("R5 rising hit low", int'(pwmOut), 0);
    tick(2);                                   // after edge 24
    chk("R1 before second top", int'(ovfFlag), 0);
    tick(1);                                   // after edge 25
    chk("R1 second top", int'(ovfFlag), 1);

    // R9 compare change waits for the next top
    start(8, 5, 2'b10);
    tick(11);                                  // after edge 10
    cmpIn = 16'd2;
    tick(2);                                   // after edge 12
    chk("R9 old compare falling", int'(pwmOut), 1);
    tick(10);                                  // after edge 22
    chk("R9 old compare rising", int'(pwmOut), 0);
    tick(8);                                   // after edge 30
    chk("R9 before new hit", int'(pwmOut), 0);
    tick(1);                                   // after edge 31
    chk("R9 new compare", int'(pwmOut), 1);

    // R4 pin left alone, flag still works
    start(8, 5, 2'b10);
    tick(13);                                  // after edge 12
    edgeSel = 2'b00;
    clrMatch = 1'b1;
    tick(1);
    clrMatch = 1'b0;
    chk("R4 flag cleared", int'(matchFlag), 0);
    tick(30);
    chk("R4 pin held", int'(pwmOut), 1);
    chk("R4 flag sets", int'(matchFlag), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule